// File: doc/BRIEF.md
# Masked Destination Address and Multicast Hash Filter

This block decides whether a received layer-2 destination address is wanted by the station. Each lookup is presented as a 48-bit address with a one-cycle strobe. The address is compared against sixteen programmable address entries. Each entry has its own don't-care mask and its own enable bit. In parallel, a CRC-32 of the six address octets selects one bit of a 256-bit multicast bitmap.

Both results appear together on a registered result pulse. The first stage computes the CRC. The second stage performs the compares and the bitmap lookup. The address entries, masks, enables, hash enable and bitmap words are loaded through a simple write port that takes a kind code, an index and data.

Top module: `l2_da_filter`

## Requirements
- R1: Entry i hits when every bit of the address outside its mask agrees with the stored address; a mask bit of 1 makes that address bit don't-care, so an all-ones mask hits any address.
- R2: The first octet on the wire occupies `da[47:40]` and the last occupies `da[7:0]`; the CRC consumes `da[47:40]` first.
- R3: Enable bit i (bit 0 for entry 0) gates entry i; a disabled entry never produces `match`, whatever its address and mask.
- R4: When more than one enabled entry hits, `match_idx` reports the lowest-numbered one.
- R5: The hash is a reflected CRC-32 (polynomial 0xEDB88320, start value 0xFFFFFFFF, each octet taken least significant bit first, no final inversion); bits 31:24 of the result index the bitmap, and `hash_hit` is the indexed bitmap bit.
- R6: A bitmap write to word w (0..15) loads bitmap bits 16w+15 down to 16w from `wr_data[15:0]`.
- R7: `hash_hit` is 0 unless the hash enable is 1 and the address group bit `da[40]` is 1.
- R8: `result_valid` pulses high exactly two cycles after each `da_valid` cycle; while it is low, `match`, `match_idx` and `hash_hit` are 0.
- R9: After reset all entries, masks, enables, the hash enable and the bitmap are 0, so no lookup matches or hashes, and all outputs are 0.
- R10: A write with `wr_en` high applies by `wr_kind`: 0 loads address `wr_idx` from `wr_data`, 1 loads mask `wr_idx`, 2 loads bitmap word `wr_idx`, 3 loads the enables from `wr_data[15:0]` and the hash enable from `wr_data[16]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Strobe: `da` holds an address to look up |
| da | input | 48 | Destination address, first octet in bits 47:40 |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 2 | Write target: 0 address, 1 mask, 2 bitmap word, 3 enables |
| wr_idx | input | 4 | Entry or bitmap word index |
| wr_data | input | 48 | Write data |
| result_valid | output | 1 | Lookup result valid pulse |
| match | output | 1 | An enabled entry hit |
| match_idx | output | 4 | Lowest hitting entry |
| hash_hit | output | 1 | Multicast bitmap hit |

## Verification
Each lookup strobe is driven for one cycle. Two rising edges later, `result_valid`, `match`, `match_idx` and `hash_hit` are all due together. The bench checks that nothing is valid after the first edge. It then samples the result on the falling edge after the second edge. Configuration writes are always finished before a strobe, so a result never depends on a write arriving in the middle of a lookup.

// File: rtl/l2_da_filter.sv
module l2_da_filter #(
  parameter int N_ENT = 16,
  parameter int IDX_W = 4,
  parameter int HBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             da_valid,
  input  logic [47:0]      da,
  input  logic             wr_en,
  input  logic [1:0]       wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [47:0]      wr_data,
  output logic             result_valid,
  output logic             match,
  output logic [IDX_W-1:0] match_idx,
  output logic             hash_hit
);
  localparam int TBL = 1 << HBITS;
  localparam int NW  = TBL / 16;

  logic [47:0]      addr_q [N_ENT];
  logic [47:0]      mask_q [N_ENT];
  logic [N_ENT-1:0] en_q;
  logic             hen_q;
  logic [TBL-1:0]   tbl_q;

  logic             s1_v;
  logic [47:0]      s1_da;
  logic [HBITS-1:0] s1_hidx;

  function automatic logic [31:0] crc_da(input logic [47:0] d);
    logic [31:0] c;
    logic [7:0]  oct;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      oct = d[47-8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ oct[i];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return c;
  endfunction

  logic [31:0] crc_now;
  assign crc_now = crc_da(da);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        addr_q[i] <= '0;
        mask_q[i] <= '0;
      end
      en_q  <= '0;
      hen_q <= 1'b0;
      tbl_q <= '0;
    end else if (wr_en) begin
      case (wr_kind)
        2'd0: addr_q[wr_idx] <= wr_data;
        2'd1: mask_q[wr_idx] <= wr_data;
        2'd2: for (int w = 0; w < NW; w++)
                if (wr_idx == IDX_W'(w)) tbl_q[w*16 +: 16] <= wr_data[15:0];
        default: begin
          en_q  <= wr_data[N_ENT-1:0];
          hen_q <= wr_data[16];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_da   <= '0;
      s1_hidx <= '0;
    end else begin
      s1_v <= da_valid;
      if (da_valid) begin
        s1_da   <= da;
        s1_hidx <= crc_now[31 -: HBITS];
      end
    end
  end

  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;

  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (en_q[i] && (((s1_da ^ addr_q[i]) & ~mask_q[i]) == '0)) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  logic hash_now;
  assign hash_now = hen_q & s1_da[40] & tbl_q[s1_hidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      match        <= 1'b0;
      match_idx    <= '0;
      hash_hit     <= 1'b0;
    end else begin
      result_valid <= s1_v;
      match        <= s1_v & any_hit;
      match_idx    <= (s1_v && any_hit) ? hit_idx : '0;
      hash_hit     <= s1_v & hash_now;
    end
  end
endmodule

// File: rtl/l2_da_filter_chk.sv
module l2_da_filter_chk #(
  parameter int N_ENT = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             da_valid,
  input logic             da_grp,
  input logic             result_valid,
  input logic             match,
  input logic [IDX_W-1:0] match_idx,
  input logic             hash_hit,
  input logic [N_ENT-1:0] en
);
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> ##1 result_valid);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(da_valid, 2));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> (!match && !hash_hit && match_idx == '0));

  p_enabled_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> en[match_idx]);

  p_group_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da_grp) |=> ##1 !hash_hit);
endmodule

bind l2_da_filter l2_da_filter_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_grp(da[40]),
  .result_valid(result_valid), .match(match), .match_idx(match_idx),
  .hash_hit(hash_hit), .en(en_q)
);

// File: tb/l2_da_filter_test.sv
module l2_da_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [3:0]  wr_idx = '0;
  logic [47:0] wr_data = '0;
  logic        result_valid, match, hash_hit;
  logic [3:0]  match_idx;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  l2_da_filter uut (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
    .result_valid(result_valid), .match(match), .match_idx(match_idx),
    .hash_hit(hash_hit)
  );

  function automatic logic [7:0] ref_hidx(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] o = d[47-8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ o[i];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return c[31:24];
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input logic [3:0] i, input logic [47:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [47:0] a, output logic m, output logic [3:0] ix,
                      output logic h);
    @(negedge clk);
    da = a; da_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    da_valid = 1'b0;
    chk("R8 early", {47'd0, result_valid}, 48'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 valid", {47'd0, result_valid}, 48'd1);
    m = match; ix = match_idx; h = hash_hit;
    @(posedge clk);
    @(negedge clk);
    chk("R8 pulse", {47'd0, result_valid}, 48'd0);
    chk("R8 quiet", {45'd0, match, hash_hit, |match_idx}, 48'd0);
  endtask

  task automatic t_reset();
    logic m, h; logic [3:0] ix;
    chk("R9 valid", {47'd0, result_valid}, 48'd0);
    chk("R9 outs", {47'd0, match | hash_hit}, 48'd0);
    look(48'h0, m, ix, h);
    chk("R9 no match", {47'd0, m}, 48'd0);
    look(48'h0100_0000_0000, m, ix, h);
    chk("R9 no hash", {47'd0, h}, 48'd0);
  endtask

  task automatic t_exact();
    logic m, h; logic [3:0] ix;
    wr(2'd0, 4'd3, 48'h0123_4567_89AB);
    wr(2'd1, 4'd3, 48'h0);
    wr(2'd3, 4'd0, 48'h0_0008);
    look(48'h0123_4567_89AB, m, ix, h);
    chk("R1 exact hit", {43'd0, m, ix}, {43'd0, 1'b1, 4'd3});
    look(48'h0123_4567_89AA, m, ix, h);
    chk("R1 one-bit miss", {47'd0, m}, 48'd0);
    look(48'hAB89_6745_2301, m, ix, h);
    chk("R2 reversed octets miss", {47'd0, m}, 48'd0);
  endtask

  task automatic t_mask();
    logic m, h; logic [3:0] ix;
    wr(2'd1, 4'd3, 48'h0000_0000_00FF);
    look(48'h0123_4567_8955, m, ix, h);
    chk("R1 masked low octet", {43'd0, m, ix}, {43'd0, 1'b1, 4'd3});
    look(48'h0123_4567_88AB, m, ix, h);
    chk("R1 unmasked bit differs", {47'd0, m}, 48'd0);
    wr(2'd1, 4'd3, 48'hFFFF_FFFF_FFFF);
    look(48'hDEAD_BEEF_0000, m, ix, h);
    chk("R1 all-ones mask", {43'd0, m, ix}, {43'd0, 1'b1, 4'd3});
  endtask

  task automatic t_enable_prio();
    logic m, h; logic [3:0] ix;
    wr(2'd0, 4'd9, 48'h0000_0000_0042);
    wr(2'd0, 4'd15, 48'h0000_0000_0042);
    wr(2'd3, 4'd0, 48'h0_8000);
    look(48'h0000_0000_0042, m, ix, h);
    chk("R3 enable bit 15", {43'd0, m, ix}, {43'd0, 1'b1, 4'd15});
    wr(2'd3, 4'd0, 48'h0_8208);
    look(48'h0000_0000_0042, m, ix, h);
    chk("R4 lowest wins", {43'd0, m, ix}, {43'd0, 1'b1, 4'd3});
    wr(2'd3, 4'd0, 48'h0_8200);
    look(48'h0000_0000_0042, m, ix, h);
    chk("R4 next lowest", {43'd0, m, ix}, {43'd0, 1'b1, 4'd9});
    wr(2'd3, 4'd0, 48'h0_0000);
    look(48'h0000_0000_0042, m, ix, h);
    chk("R3 all disabled", {47'd0, m}, 48'd0);
  endtask

  task automatic t_hash();
    logic m, h; logic [3:0] ix;
    logic [47:0] mc = 48'h0100_5E00_00FB;
    logic [7:0]  hi = ref_hidx(mc);
    wr(2'd2, hi[7:4], 48'd1 << hi[3:0]);
    wr(2'd3, 4'd0, 48'h1_0000);
    look(mc, m, ix, h);
    chk("R5 hash hit", {47'd0, h}, 48'd1);
    chk("R10 hash only, no match", {47'd0, m}, 48'd0);
    wr(2'd2, hi[7:4], ~(48'd1 << hi[3:0]));
    look(mc, m, ix, h);
    chk("R6 bit cleared in word", {47'd0, h}, 48'd0);
    wr(2'd2, hi[7:4], 48'hFFFF);
    wr(2'd3, 4'd0, 48'h0_0000);
    look(mc, m, ix, h);
    chk("R7 hash disabled", {47'd0, h}, 48'd0);
    wr(2'd3, 4'd0, 48'h1_0000);
    for (int w = 0; w < 16; w++) wr(2'd2, 4'(w), 48'hFFFF);
    look(48'h0200_0000_0001, m, ix, h);
    chk("R7 unicast no hash", {47'd0, h}, 48'd0);
    look(48'h0300_0000_0001, m, ix, h);
    chk("R6 full table hit", {47'd0, h}, 48'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_mask();
    t_enable_prio();
    t_hash();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule